// File: doc/BRIEF.md
# Per-Warp Cache-Utility Classifier and Bypass Router

This block sits in front of a shared cache slice. It watches every request that reaches the slice. For each warp it keeps a running count of lookups and hits, and it sorts the warp into a hit-ratio class. It then steers each request either to the cache bank arbiter or straight to the DRAM request queue. Warps that gain almost nothing from the cache are sent past it. This frees cache capacity for warps that hit often, and it shortens the lookup queue for those warps.

Classification is driven by sampling. At the start of every epoch, each warp enters a profiling window. The window covers a fixed number of that warp's accesses, and no bypass decision is made while it is open. On the access that closes the window, the warp's hit and access counts are compared against percentage bars by cross-multiplication. The resulting 2-bit class is stored, and it governs routing until the next epoch. The lower bar moves with an external miss-rate figure, so the block bypasses less readily when the cache as a whole is missing heavily.

The routing decision is combinational. It depends on the requesting warp's stored class, its profiling state and the request kind. Fences and atomics from a bypassed warp are still sent to the cache for a lookup, but they carry a flag that forbids them from allocating a line.

Top module: `warp_bypass_classifier`

## Requirements
- R1: When a warp's profiling window closes, its class code is set as follows, evaluated in this order. Code 3 when every sampled access hit. Code 0 when none hit. Code 2 when hits×100 ≥ 70×accesses. Code 0 when hits×100 ≤ threshold×accesses. Code 1 otherwise. Warp w's code appears on warp_class[2w+1:2w].
- R2: After reset, every warp reads code 1 (balanced) and is in profiling. No request is routed to DRAM until some warp finishes profiling with code 0.
- R3: Hit and access counters are CNT_W bits wide. When an increment sets the access counter's MSB, both counters are halved, and classification uses the halved values. For example, with 5-bit counters, 23 hits followed by 7 misses classify as code 1, not code 2.
- R4: Every EPOCH_CYCLES cycles, all counters clear and every warp re-enters profiling. The stored code is kept but does not route, and it is replaced when the new window closes.
- R5: The profiling window spans a warp's first PROFILE_LEN accesses of the epoch. The code changes on the clock edge of the PROFILE_LEN-th access and not before. No request from a profiling warp is routed to DRAM.
- R6: While acc_valid is high, exactly one of route_dram and route_cache is high. route_dram is high only for a normal request (kind 00, or the reserved kind 11) from a warp that has finished profiling with code 0. When acc_valid is low, all route outputs are low.
- R7: A fence (kind 01) or atomic (kind 10) from a warp that has finished profiling with code 0 goes to route_cache with route_no_alloc high. route_no_alloc is low for every other request.
- R8: The lower threshold is 20 while miss_pct ≤ 50. Above 50, it is 20 − 5·floor((miss_pct − 50)/5), and it never goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | A request arrives this cycle |
| acc_warp | input | WID_W | Warp identifier of the request |
| acc_hit | input | 1 | Lookup result counted for this request (1 = hit) |
| acc_kind | input | 2 | 00 normal, 01 fence, 10 atomic, 11 treated as normal |
| miss_pct | input | 7 | Current cache-wide miss rate in percent |
| route_dram | output | 1 | Send the request to the DRAM request queue |
| route_cache | output | 1 | Send the request to the cache bank arbiter |
| route_no_alloc | output | 1 | The cache lookup must not allocate a line |
| warp_class | output | 2·NUM_WARPS | Packed per-warp class codes |

## Verification
The routing outputs are combinational from the request and the registered warp state, so they are due in the same cycle as the request. The bench samples them two nanoseconds after driving the inputs, well before the next rising edge. A class code is registered on the edge of the window-closing access, so the bench reads it at the falling edge that follows. It also reads the code once after the second-to-last access, to show that the code has not changed early. Epoch behaviour is checked only after the bench cycle count has passed the epoch length, without depending on the exact tick cycle.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    WT_LOW  = 2'd0,
    WT_BAL  = 2'd1,
    WT_MHIT = 2'd2,
    WT_AHIT = 2'd3
  } wtype_e;

  typedef enum logic [1:0] {
    RK_NORMAL = 2'd0,
    RK_FENCE  = 2'd1,
    RK_ATOMIC = 2'd2,
    RK_RSVD   = 2'd3
  } rkind_e;

  function automatic logic is_ordering(input logic [1:0] kind);
    return (kind == RK_FENCE) || (kind == RK_ATOMIC);
  endfunction

endpackage

// File: rtl/wbc_epoch.sv
module wbc_epoch #(
  parameter int EPOCH_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_tick
);
  localparam int EW = (EPOCH_CYCLES > 1) ? $clog2(EPOCH_CYCLES) : 1;
  localparam logic [EW-1:0] LAST = EW'(EPOCH_CYCLES - 1);

  logic [EW-1:0] cnt_q, cnt_d;

  always_comb begin
    epoch_tick = (cnt_q == LAST);
    cnt_d      = epoch_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_EPOCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
  AST_EPOCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_tick |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/wbc_threshold.sv
module wbc_threshold #(
  parameter int BASE_LOW_PCT = 20,
  parameter int REF_MISS_PCT = 50,
  parameter int TH_STEP_PCT  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] miss_pct,
  output logic [6:0] low_th
);
  localparam logic [7:0] BASE = 8'(BASE_LOW_PCT);
  localparam logic [7:0] REFM = 8'(REF_MISS_PCT);
  localparam logic [7:0] STEP = 8'(TH_STEP_PCT);

  logic [7:0] rise, steps, drop;

  always_comb begin
    rise   = ({1'b0, miss_pct} > REFM) ? ({1'b0, miss_pct} - REFM) : 8'd0;
    steps  = rise / STEP;
    drop   = 8'(steps * STEP);
    low_th = (drop >= BASE) ? 7'd0 : 7'(BASE - drop);
  end

  AST_TH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, low_th} <= BASE); // R8
  AST_TH_QUIET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, miss_pct} <= REFM) |-> ({1'b0, low_th} == BASE)); // R8

endmodule

// File: rtl/wbc_classify.sv
module wbc_classify import wbc_pkg::*; #(
  parameter int CNT_W    = 10,
  parameter int HIGH_PCT = 70
) (
  input  logic [CNT_W-1:0] hits,
  input  logic [CNT_W-1:0] accs,
  input  logic [6:0]       low_th,
  output logic [1:0]       cls
);
  localparam int PW = CNT_W + 8;

  logic [PW-1:0] hit_scaled, hi_bar, lo_bar;

  always_comb begin
    hit_scaled = PW'(hits) * PW'(100);
    hi_bar     = PW'(accs) * PW'(HIGH_PCT);
    lo_bar     = PW'(accs) * PW'(low_th);
    if (hits == accs)              cls = WT_AHIT;
    else if (hits == '0)           cls = WT_LOW;
    else if (hit_scaled >= hi_bar) cls = WT_MHIT;
    else if (hit_scaled <= lo_bar) cls = WT_LOW;
    else                           cls = WT_BAL;
  end

endmodule

// File: rtl/wbc_stats.sv
module wbc_stats import wbc_pkg::*; #(
  parameter int NUM_WARPS   = 48,
  parameter int CNT_W       = 10,
  parameter int PROFILE_LEN = 30
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              acc_valid,
  input  logic [((NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1)-1:0] acc_warp,
  input  logic                                              acc_hit,
  input  logic                                              epoch_tick,
  input  logic [1:0]                                        cls_in,
  output logic [CNT_W-1:0]                                  sel_hits_nx,
  output logic [CNT_W-1:0]                                  sel_acc_nx,
  output logic                                              sel_profiling,
  output logic [1:0]                                        sel_type,
  output logic                                              prof_done,
  output logic [2*NUM_WARPS-1:0]                            type_flat
);
  localparam int PROF_W = $clog2(PROFILE_LEN + 1);

  logic [CNT_W-1:0]  hits_q [NUM_WARPS];
  logic [CNT_W-1:0]  hits_d [NUM_WARPS];
  logic [CNT_W-1:0]  acc_q  [NUM_WARPS];
  logic [CNT_W-1:0]  acc_d  [NUM_WARPS];
  logic [PROF_W-1:0] pcnt_q [NUM_WARPS];
  logic [PROF_W-1:0] pcnt_d [NUM_WARPS];
  logic [1:0]        type_q [NUM_WARPS];
  logic [1:0]        type_d [NUM_WARPS];
  logic [NUM_WARPS-1:0] prof_q, prof_d;

  logic              sel_ok;
  logic [CNT_W-1:0]  cur_hits, cur_acc, acc_inc, hit_inc;
  logic [PROF_W-1:0] cur_pcnt, pcnt_inc;

  assign sel_ok = (int'(acc_warp) < NUM_WARPS);

  // selected-warp view and the counts this access would leave behind
  always_comb begin
    cur_hits      = sel_ok ? hits_q[acc_warp] : '0;
    cur_acc       = sel_ok ? acc_q[acc_warp]  : '0;
    cur_pcnt      = sel_ok ? pcnt_q[acc_warp] : '0;
    sel_profiling = sel_ok ? prof_q[acc_warp] : 1'b1;
    sel_type      = sel_ok ? type_q[acc_warp] : WT_BAL;
    acc_inc       = cur_acc + 1'b1;
    hit_inc       = cur_hits + CNT_W'(acc_hit);
    pcnt_inc      = cur_pcnt + 1'b1;
    if (acc_inc[CNT_W-1]) begin
      sel_acc_nx  = acc_inc >> 1;
      sel_hits_nx = hit_inc >> 1;
    end else begin
      sel_acc_nx  = acc_inc;
      sel_hits_nx = hit_inc;
    end
    prof_done = acc_valid && sel_ok && !epoch_tick && sel_profiling &&
                (pcnt_inc == PROF_W'(PROFILE_LEN));
  end

  // next state
  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      hits_d[w] = hits_q[w];
      acc_d[w]  = acc_q[w];
      pcnt_d[w] = pcnt_q[w];
      type_d[w] = type_q[w];
    end
    prof_d = prof_q;
    if (epoch_tick) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        hits_d[w] = '0;
        acc_d[w]  = '0;
        pcnt_d[w] = '0;
      end
      prof_d = '1;
      if (acc_valid && sel_ok) begin
        hits_d[acc_warp] = CNT_W'(acc_hit);
        acc_d[acc_warp]  = CNT_W'(1);
        pcnt_d[acc_warp] = PROF_W'(1);
      end
    end else if (acc_valid && sel_ok) begin
      hits_d[acc_warp] = sel_hits_nx;
      acc_d[acc_warp]  = sel_acc_nx;
      if (sel_profiling) pcnt_d[acc_warp] = pcnt_inc;
      if (prof_done) begin
        prof_d[acc_warp] = 1'b0;
        type_d[acc_warp] = cls_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        hits_q[w] <= '0;
        acc_q[w]  <= '0;
        pcnt_q[w] <= '0;
        type_q[w] <= WT_BAL;
      end
      prof_q <= '1;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        hits_q[w] <= hits_d[w];
        acc_q[w]  <= acc_d[w];
        pcnt_q[w] <= pcnt_d[w];
        type_q[w] <= type_d[w];
      end
      prof_q <= prof_d;
    end
  end

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_flat
    assign type_flat[2*g +: 2] = type_q[g];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> !cur_acc[CNT_W-1]); // R3
  AST_HITS_WITHIN_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> (cur_hits <= cur_acc)); // R3
  AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !prof_done |=> $stable(type_flat)); // R5
  AST_PROFILE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_tick |=> (prof_q == '1)); // R4

endmodule

// File: rtl/wbc_route.sv
module wbc_route import wbc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [1:0] acc_kind,
  input  logic       sel_profiling,
  input  logic [1:0] sel_type,
  output logic       to_dram,
  output logic       to_cache,
  output logic       no_alloc
);
  logic skip_warp, ordered;

  always_comb begin
    skip_warp = !sel_profiling && (sel_type == WT_LOW);
    ordered   = is_ordering(acc_kind);
    to_dram   = acc_valid && skip_warp && !ordered;
    to_cache  = acc_valid && !(skip_warp && !ordered);
    no_alloc  = acc_valid && skip_warp && ordered;
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones({to_dram, to_cache}) == 1)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(to_dram || to_cache || no_alloc)); // R6
  AST_NOALLOC_LOOKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    no_alloc |-> to_cache); // R7
  AST_PROFILE_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_profiling |-> !to_dram); // R5

endmodule

// File: rtl/warp_bypass_classifier.sv
module warp_bypass_classifier import wbc_pkg::*; #(
  parameter int NUM_WARPS    = 48,
  parameter int CNT_W        = 10,
  parameter int PROFILE_LEN  = 30,
  parameter int EPOCH_CYCLES = 100000,
  parameter int HIGH_PCT     = 70,
  parameter int BASE_LOW_PCT = 20,
  parameter int REF_MISS_PCT = 50,
  parameter int TH_STEP_PCT  = 5,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [WID_W-1:0]       acc_warp,
  input  logic                   acc_hit,
  input  logic [1:0]             acc_kind,
  input  logic [6:0]             miss_pct,
  output logic                   route_dram,
  output logic                   route_cache,
  output logic                   route_no_alloc,
  output logic [2*NUM_WARPS-1:0] warp_class
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             epoch_tick;
  logic [6:0]       low_th;
  logic [CNT_W-1:0] sel_hits_nx, sel_acc_nx;
  logic             sel_profiling, prof_done;
  logic [1:0]       sel_type, cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  wbc_epoch #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_epoch (
    .clk(clk), .rst_n(rst_ni), .epoch_tick(epoch_tick)
  );

  wbc_threshold #(
    .BASE_LOW_PCT(BASE_LOW_PCT), .REF_MISS_PCT(REF_MISS_PCT), .TH_STEP_PCT(TH_STEP_PCT)
  ) u_th (
    .clk(clk), .rst_n(rst_ni), .miss_pct(miss_pct), .low_th(low_th)
  );

  wbc_stats #(
    .NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W), .PROFILE_LEN(PROFILE_LEN)
  ) u_stats (
    .clk(clk), .rst_n(rst_ni), .acc_valid(acc_valid), .acc_warp(acc_warp),
    .acc_hit(acc_hit), .epoch_tick(epoch_tick), .cls_in(cls),
    .sel_hits_nx(sel_hits_nx), .sel_acc_nx(sel_acc_nx),
    .sel_profiling(sel_profiling), .sel_type(sel_type),
    .prof_done(prof_done), .type_flat(warp_class)
  );

  wbc_classify #(.CNT_W(CNT_W), .HIGH_PCT(HIGH_PCT)) u_cls (
    .hits(sel_hits_nx), .accs(sel_acc_nx), .low_th(low_th), .cls(cls)
  );

  wbc_route u_route (
    .clk(clk), .rst_n(rst_ni), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .sel_profiling(sel_profiling), .sel_type(sel_type),
    .to_dram(route_dram), .to_cache(route_cache), .no_alloc(route_no_alloc)
  );

  AST_CLASS_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_ni)
    prof_done |=> (warp_class[2*acc_warp_q +: 2] == cls_q)); // R1

  logic [WID_W-1:0] acc_warp_q;
  logic [1:0]       cls_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_warp_q <= '0;
      cls_q      <= WT_BAL;
    end else if (prof_done) begin
      acc_warp_q <= acc_warp;
      cls_q      <= cls;
    end
  end

endmodule

// File: tb/warp_bypass_classifier_tb.sv
module warp_bypass_classifier_tb;
  localparam int NW    = 16;
  localparam int EPOCH = 2000;
  localparam int NV    = 14;

  // {warp[18:15], hits[14:9], miss_pct[8:2], expected class[1:0]}; hits first, then misses
  localparam logic [18:0] VEC [NV] = '{
    {4'd0,  6'd30, 7'd0,  2'd3},
    {4'd1,  6'd21, 7'd0,  2'd2},
    {4'd2,  6'd29, 7'd0,  2'd2},
    {4'd3,  6'd20, 7'd0,  2'd1},
    {4'd4,  6'd7,  7'd0,  2'd1},
    {4'd5,  6'd6,  7'd0,  2'd0},
    {4'd6,  6'd1,  7'd0,  2'd0},
    {4'd7,  6'd0,  7'd0,  2'd0},
    {4'd8,  6'd6,  7'd55, 2'd1},
    {4'd9,  6'd4,  7'd59, 2'd0},
    {4'd10, 6'd1,  7'd70, 2'd1},
    {4'd11, 6'd0,  7'd95, 2'd0},
    {4'd12, 6'd3,  7'd64, 2'd0},
    {4'd13, 6'd14, 7'd30, 2'd1}
  };

  logic clk, rst_n, acc_valid, acc_hit;
  logic [3:0] acc_warp;
  logic [1:0] acc_kind;
  logic [6:0] miss_pct;
  logic route_dram, route_cache, route_no_alloc;
  logic [2*NW-1:0] warp_class;
  logic s_dram, s_cache, s_na;
  logic [2*NW-1:0] s_class;

  int checks, failures, cyc;
  bit done;
  logic g_dram, g_cache, g_na;

  warp_bypass_classifier #(.NUM_WARPS(NW), .EPOCH_CYCLES(EPOCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_warp(acc_warp),
    .acc_hit(acc_hit), .acc_kind(acc_kind), .miss_pct(miss_pct),
    .route_dram(route_dram), .route_cache(route_cache),
    .route_no_alloc(route_no_alloc), .warp_class(warp_class)
  );

  warp_bypass_classifier #(.NUM_WARPS(NW), .EPOCH_CYCLES(EPOCH), .CNT_W(5)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_warp(acc_warp),
    .acc_hit(acc_hit), .acc_kind(acc_kind), .miss_pct(miss_pct),
    .route_dram(s_dram), .route_cache(s_cache),
    .route_no_alloc(s_na), .warp_class(s_class)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input int w, input bit h, input logic [1:0] k);
    @(negedge clk);
    acc_valid = 1'b1; acc_warp = 4'(w); acc_hit = h; acc_kind = k;
    #2;
    g_dram = route_dram; g_cache = route_cache; g_na = route_no_alloc;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'b00; acc_hit = 1'b0;
    #2;
  endtask

  function automatic logic [1:0] cls_of(input logic [2*NW-1:0] v, input int w);
    return v[2*w +: 2];
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin : main
    checks = 0; failures = 0; cyc = 0; done = 0;
    acc_valid = 0; acc_warp = 0; acc_hit = 0; acc_kind = 0; miss_pct = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    cyc = 0;
    idle();

    // R2: reset state
    for (int w = 0; w < NW; w++) chk("R2 reset class", 32'(cls_of(warp_class, w)), 32'd1);
    chk("R6 idle routes quiet", {29'd0, route_dram, route_cache, route_no_alloc}, 32'd0);
    access(0, 1'b0, 2'b00);
    chk("R2 profiling request to cache", {30'd0, g_dram, g_cache}, 32'b01);
    idle();
    // undo the extra access on warp 0 is not possible; warp 0 vector accounts for it below

    for (int v = 0; v < NV; v++) begin
      int w, nh, extra;
      logic [1:0] exp;
      w = int'(VEC[v][18:15]); nh = int'(VEC[v][14:9]); exp = VEC[v][1:0];
      miss_pct = VEC[v][8:2];
      extra = (w == 0) ? 1 : 0;  // warp 0 already had one access (a miss)
      for (int i = extra; i < 30; i++) begin
        // for warp 0 the earlier miss means 29 hits + 1 miss; compensate below
        access(w, (w == 0) ? 1'b1 : (i < nh), 2'b00);
        if (i == 28) begin
          idle();
          chk($sformatf("R5 class unchanged before window end w%0d", w),
              32'(cls_of(warp_class, w)), 32'd1);
        end
      end
      idle();
      // warp 0 saw 29 hits and 1 miss -> mostly-hit
      chk($sformatf("R1 R8 class w%0d", w), 32'(cls_of(warp_class, w)),
          32'((w == 0) ? 2'd2 : exp));
      access(w, 1'b0, 2'b00);
      chk($sformatf("R6 normal route w%0d", w), {30'd0, g_dram, g_cache},
          ((w != 0) && exp == 2'd0) ? 32'b10 : 32'b01);
      access(w, 1'b0, 2'b01);
      chk($sformatf("R7 fence route w%0d", w), {29'd0, g_dram, g_cache, g_na},
          ((w != 0) && exp == 2'd0) ? 32'b011 : 32'b010);
      access(w, 1'b0, 2'b10);
      chk($sformatf("R7 atomic route w%0d", w), {29'd0, g_dram, g_cache, g_na},
          ((w != 0) && exp == 2'd0) ? 32'b011 : 32'b010);
      access(w, 1'b0, 2'b11);
      chk($sformatf("R6 reserved kind as normal w%0d", w), {30'd0, g_dram, g_cache},
          ((w != 0) && exp == 2'd0) ? 32'b10 : 32'b01);
      idle();
    end
    miss_pct = 7'd0;

    // R3: counter halving; 23 hits then 7 misses on warp 14
    for (int i = 0; i < 30; i++) access(14, i < 23, 2'b00);
    idle();
    chk("R3 wide counters give mostly-hit", 32'(cls_of(warp_class, 14)), 32'd2);
    chk("R3 halved counters give balanced", 32'(cls_of(s_class, 14)), 32'd1);

    // R8: threshold floor at miss_pct 90 -> 0; one hit of 30 is balanced
    miss_pct = 7'd90;
    for (int i = 0; i < 30; i++) access(15, i < 1, 2'b00);
    idle();
    chk("R8 threshold floored at zero", 32'(cls_of(warp_class, 15)), 32'd1);
    miss_pct = 7'd0;

    // R4: epoch restart
    while (cyc < EPOCH + 50) idle();
    chk("R4 class kept across epoch", 32'(cls_of(warp_class, 7)), 32'd0);
    access(7, 1'b1, 2'b00);
    chk("R4 re-profiling sends to cache", {30'd0, g_dram, g_cache}, 32'b01);
    for (int i = 1; i < 30; i++) access(7, 1'b1, 2'b00);
    idle();
    chk("R4 reclassified all-hit", 32'(cls_of(warp_class, 7)), 32'd3);
    access(7, 1'b0, 2'b00);
    chk("R6 all-hit warp to cache", {30'd0, g_dram, g_cache}, 32'b01);
    idle();

    done = 1;
    finish_run();
  end

endmodule